// File: doc/BRIEF.md
# Video Pixel Shift Register

This block turns one byte of a character row into a stream of pixels for a display. On each rising clock edge it does one of four things. It can capture the byte as presented. It can capture the byte inverted, for reverse video. It can move its contents one place toward the least significant bit. Or it can fill itself with ones to draw a solid cursor block.

Bit 0 of the register is the pixel shown on the current cycle. The whole register is also brought out so that a neighbour can watch the remaining pixels. As the contents move down, zeros enter at the top, so a byte that has been shifted out completely leaves a blank line segment behind. The load and reset controls are active low.

Top module: `pixel_shift_reg`

## Requirements
- R1: When `rst_n` is 0 at a rising edge, all bits of `q` become 0 after that edge, whatever the other inputs are.
- R2: When `rst_n` is 1 and `cursor_on` is 1 at a rising edge, all bits of `q` become 1 after that edge, whatever `load_n`, `rev_video` and `data_in` are.
- R3: When `rst_n` is 1, `cursor_on` is 0, `load_n` is 0 and `rev_video` is 0 at a rising edge, `q` becomes `data_in` unchanged.
- R4: When `rst_n` is 1, `cursor_on` is 0, `load_n` is 0 and `rev_video` is 1 at a rising edge, `q` becomes the bitwise complement of `data_in`.
- R5: When `rst_n` is 1, `cursor_on` is 0 and `load_n` is 1 at a rising edge, bit n of `q` takes the old bit n+1. `rev_video` and `data_in` have no effect.
- R6: During a shift (as in R5), the most significant bit of `q` becomes 0.
- R7: `pixel_out` always equals bit 0 of `q`.
- R8: After a load (R3 or R4), eight shift cycles in a row with no cursor and no reset leave `q` all zeros.
- R9: `q` changes only at a rising clock edge; input changes between edges do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; highest priority |
| load_n | input | 1 | Parallel capture request, active low |
| rev_video | input | 1 | Selects inverted capture while loading |
| cursor_on | input | 1 | Forces every bit to 1; overrides loading and shifting |
| data_in | input | 8 | Character-row byte to capture |
| q | output | 8 | Register contents |
| pixel_out | output | 1 | Current pixel, equal to bit 0 of `q` |

## Verification
On every cycle, the assertions check the priority order of reset, cursor, true load, inverted load and shift against the register's previous state and inputs. This includes the zero fill at the top and the drain to all zeros after eight shifts. The bench's scenarios are the only place where the pixel order is seen over a whole byte. They also show that `pixel_out` tracks bit 0, that `rev_video` and `data_in` are ignored while shifting, and that input changes between edges leave `q` alone.

// File: rtl/vps_pkg.sv
// Package vps_pkg
// Shared operation codes for the pixel shift register.
// Assumes: one operation is chosen per clock edge by a fixed priority.
package vps_pkg;
    typedef enum logic [2:0] {
        OP_CLEAR   = 3'd0,
        OP_CURSOR  = 3'd1,
        OP_LOAD    = 3'd2,
        OP_LOADINV = 3'd3,
        OP_SHIFT   = 3'd4
    } vps_op_e;
endpackage

// File: rtl/vps_mode_decode.sv
// Module vps_mode_decode
// Picks the single operation for the coming edge.
// Priority order: reset, cursor, load (true or inverted), shift.
// Assumes: rst_n and load_n are active low.
module vps_mode_decode
    import vps_pkg::*;
(
    input  logic    rst_n,
    input  logic    load_n,
    input  logic    rev_video,
    input  logic    cursor_on,
    output vps_op_e op
);
    // Priority decode of the control inputs
    always_comb begin
        if (!rst_n)
            op = OP_CLEAR;
        else if (cursor_on)
            op = OP_CURSOR;
        else if (!load_n)
            op = rev_video ? OP_LOADINV : OP_LOAD;
        else
            op = OP_SHIFT;
    end
endmodule

// File: rtl/vps_bit_slice.sv
// Module vps_bit_slice
// Next-state selector for one register bit.
// Assumes: 'above' is the old value of the next higher bit, or the fill
// value when this is the top bit.
module vps_bit_slice
    import vps_pkg::*;
(
    input  vps_op_e op,
    input  logic    din,
    input  logic    above,
    output logic    nxt
);
    // Choose this bit's next value from the operation
    always_comb begin
        unique case (op)
            OP_CLEAR:   nxt = 1'b0;
            OP_CURSOR:  nxt = 1'b1;
            OP_LOAD:    nxt = din;
            OP_LOADINV: nxt = ~din;
            OP_SHIFT:   nxt = above;
            default:    nxt = 1'b0;
        endcase
    end
endmodule

// File: rtl/vps_store.sv
// Module vps_store
// The storage flops of the register.
// Assumes: reset is already folded into d by the bit slices.
module vps_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the next state on the rising edge
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/pixel_shift_reg.sv
// Module pixel_shift_reg
// Parallel-load register that serializes a byte toward bit 0. It can
// capture the byte true or inverted, and it can be forced to a cursor
// block of ones.
// Assumes: synchronous active-low reset; zeros fill from the top.
module pixel_shift_reg
    import vps_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             rev_video,
    input  logic             cursor_on,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] q,
    output logic             pixel_out
);
    localparam logic FILL = 1'b0;

    vps_op_e          op;
    logic [WIDTH-1:0] q_next;
    logic [WIDTH:0]   chain;

    vps_mode_decode u_dec (
        .rst_n     (rst_n),
        .load_n    (load_n),
        .rev_video (rev_video),
        .cursor_on (cursor_on),
        .op        (op)
    );

    // Shift chain: the top bit is fed by the fill value
    assign chain = {FILL, q};

    for (genvar n = 0; n < WIDTH; n++) begin : g_slice
        vps_bit_slice u_slice (
            .op    (op),
            .din   (data_in[n]),
            .above (chain[n+1]),
            .nxt   (q_next[n])
        );
    end

    vps_store #(.WIDTH(WIDTH)) u_store (
        .clk (clk),
        .d   (q_next),
        .q   (q)
    );

    // Pixel for the current cycle
    assign pixel_out = q[0];
endmodule

// File: rtl/pixel_shift_reg_chk.sv
// Module pixel_shift_reg_chk
// Assertion checker attached to pixel_shift_reg by bind.
// Assumes: it sees the top-level ports only.
module pixel_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             rev_video,
    input logic             cursor_on,
    input logic [WIDTH-1:0] data_in,
    input logic [WIDTH-1:0] q
);
    localparam int CW = $clog2(WIDTH + 1) + 1;

    logic          seen;
    logic          armed;
    logic [CW-1:0] shifts;

    // Marks that at least one edge has passed
    always_ff @(posedge clk) seen <= 1'b1;

    // Counts shifts since the last load
    always_ff @(posedge clk) begin
        if (!rst_n || cursor_on) begin
            armed  <= 1'b0;
            shifts <= '0;
        end else if (!load_n) begin
            armed  <= 1'b1;
            shifts <= '0;
        end else if (shifts != CW'(WIDTH)) begin
            shifts <= shifts + 1'b1;
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        seen && $past(!rst_n) |-> q == '0);

    p_cursor_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_n) && $past(cursor_on) |-> q == '1);

    p_true_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_n) && !$past(cursor_on) && !$past(load_n)
        && !$past(rev_video) |-> q == $past(data_in));

    p_inv_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_n) && !$past(cursor_on) && !$past(load_n)
        && $past(rev_video) |-> q == ~$past(data_in));

    p_shift_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_n) && !$past(cursor_on) && $past(load_n)
        |-> q[WIDTH-2:0] == $past(q[WIDTH-1:1]));

    p_top_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_n) && !$past(cursor_on) && $past(load_n)
        |-> q[WIDTH-1] == 1'b0);

    p_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen && armed && shifts == CW'(WIDTH) |-> q == '0);
endmodule

bind pixel_shift_reg pixel_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .rev_video (rev_video),
    .cursor_on (cursor_on),
    .data_in   (data_in),
    .q         (q)
);

// File: tb/test_pixel_shift_reg.sv
// Bench for pixel_shift_reg.
// A behavioural reference model is compared with the outputs after every edge.
module test_pixel_shift_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       rev_video = 1'b0;
    logic       cursor_on = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] q;
    logic       pixel_out;

    int checks = 0;
    int errors = 0;
    int model = 0;   // reference register value, 0..255
    bit done = 0;

    pixel_shift_reg i_pixel_shift_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .rev_video (rev_video),
        .cursor_on (cursor_on),
        .data_in   (data_in),
        .q         (q),
        .pixel_out (pixel_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Applies inputs at a falling edge, updates the model at the rising
    // edge, and compares at the next falling edge.
    task automatic step(input string tag, input bit r, input bit ld,
                        input bit rv, input bit cur, input int d);
        rst_n = r; load_n = ld; rev_video = rv; cursor_on = cur;
        data_in = d[7:0];
        @(posedge clk);
        if (!r)        model = 0;
        else if (cur)  model = 255;
        else if (!ld)  model = rv ? (255 - (d % 256)) : (d % 256);
        else           model = model / 2;
        @(negedge clk);
        check(tag, int'(q), model);
        check("R7 pixel", int'(pixel_out), model % 2);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr = 8'h5b;
        @(negedge clk);
        // R1: reset clears even with cursor and load requested
        step("R1 reset", 0, 0, 1, 1, 8'hff);
        step("R1 reset", 0, 1, 0, 0, 8'h00);
        // R3: true load, then R5/R6 shift through a whole byte
        step("R3 load", 1, 0, 0, 0, 8'ha5);
        // R5: rev_video and data_in ignored while shifting
        for (int k = 0; k < 7; k++)
            step("R5 shift", 1, 1, k % 2, 0, 8'h3c + k);
        step("R8 drained", 1, 1, 0, 0, 8'hff);
        check("R8 zero", int'(q), 0);
        // R4: inverted load
        step("R4 invload", 1, 0, 1, 0, 8'h0f);
        step("R6 topfill", 1, 1, 1, 0, 8'hff);
        check("R6 msb", int'(q[7]), 0);
        // R2: cursor overrides load, inverted load and shift
        step("R2 cursor", 1, 0, 0, 1, 8'h00);
        step("R2 cursor", 1, 0, 1, 1, 8'hff);
        step("R6 after cursor", 1, 1, 0, 0, 8'h00);
        check("R6 msb", int'(q), 8'h7f);
        step("R2 cursor", 1, 1, 0, 1, 8'h12);
        // R1: reset during cursor
        step("R1 over cursor", 0, 1, 0, 1, 8'h00);
        // R9: inputs wiggle between edges, q holds
        step("R3 load", 1, 0, 0, 0, 8'hc3);
        #3 data_in = 8'h55; load_n = 1'b0; cursor_on = 1'b1;
        #3 check("R9 hold", int'(q), 8'hc3);
        cursor_on = 1'b0;
        @(negedge clk);
        model = 8'h55;   // edge above captured a true load of 8'h55
        check("R9 edge", int'(q), model);
        // Mixed pseudo-random sequence
        for (int k = 0; k < 200; k++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 255;
            step("R5 mix", (lfsr % 16) != 0, (lfsr % 3) != 0, (lfsr >> 2) % 2,
                 (lfsr % 11) == 0, lfsr ^ 8'h96);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule